// File: doc/BRIEF.md
# Video Dot and Scanline Timebase

This block keeps a running position in the picture raster, measured the way the video processor sees time, while being stepped by the CPU clock. Each CPU cycle in which the advance enable is high moves the dot position forward by a fixed number of dots. A full line is a fixed number of dots; crossing the end of a line carries the leftover dots into the next line and steps the scanline. The last line of the frame is the pre-render line and is reported as -1. After it the count returns to line 0.

The outputs are plain registers, so a trace unit can sample them at any instruction boundary and print the dot index and the signed scanline beside each executed instruction. Parameters set the start dot and start scanline that synchronous reset loads, so the counts can begin at the same values as a captured reference trace.

Top module: `ppu_timebase`

## Requirements
- R1: While `rst` is high at a rising clock edge, the dot output loads START_DOT (default 0) and the scanline output loads START_LINE (default 241).
- R2: When `cpu_tick` is low and `rst` is low, neither the dot output nor the scanline output changes.
- R3: On a tick where the dot value plus 3 is below 341, the dot output becomes that sum and the scanline output is unchanged.
- R4: On a tick where the dot value plus 3 reaches 341 or more, the dot output becomes (dot + 3) - 341 and the scanline output advances by one in the same clock edge.
- R5: Internal line 261 is the pre-render line and appears on the scanline output as -1 (10-bit two's complement 0x3FF); the line that follows 260 is therefore reported as -1.
- R6: When the -1 line completes, the scanline output becomes 0.
- R7: The dot output always lies in 0..340 and the scanline output in -1..260.
- R8: Reset takes priority over `cpu_tick`: a cycle with both high loads the start values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_tick | input | 1 | One CPU cycle elapses on this edge |
| dot_count | output | 9 | Current dot within the line, unsigned |
| scanline | output | 10 | Current scanline, signed, -1 for pre-render |

## Verification
The hardest states to reach are the transition from line 260 into the pre-render line and the wrap from -1 back to 0, which lie thousands of ticks from any reset point. The bench reaches them by starting at line 241 and ticking without pause through a stored list of tick counts, each chosen to land one step before or after a line or frame boundary, so both the partial carry case (dot ending at 1 or 2) and the exact-fit case (dot ending at 0 on the frame wrap) are observed.

// File: rtl/ppu_timebase_pkg.sv
package ppu_timebase_pkg;

  // Dot position after a step, with the carry into the next line folded in.
  function automatic int unsigned step_dot(int unsigned dot, int unsigned step,
                                           int unsigned line_len);
    int unsigned sum;
    sum = dot + step;
    return (sum >= line_len) ? sum - line_len : sum;
  endfunction

  // True when a step leaves the current line.
  function automatic bit step_crosses(int unsigned dot, int unsigned step,
                                      int unsigned line_len);
    return (dot + step) >= line_len;
  endfunction

  // Internal line index after leaving the given line.
  function automatic int unsigned next_line(int unsigned line, int unsigned frame_len);
    return (line == frame_len - 1) ? 0 : line + 1;
  endfunction

  // Map a reported start line (-1 meaning pre-render) to the internal index.
  function automatic int unsigned line_index(int reported, int unsigned frame_len);
    return (reported < 0) ? frame_len - 1 : int'(reported);
  endfunction

endpackage

// File: rtl/dot_stepper.sv
module dot_stepper #(
  parameter int unsigned LINE_LEN  = 341,
  parameter int unsigned STEP      = 3,
  parameter int unsigned START_DOT = 0,
  parameter int unsigned DW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [DW-1:0] dot,
  output logic          carry
);
  import ppu_timebase_pkg::*;

  localparam int unsigned SW = DW + 1;

  logic [DW-1:0] dot_nxt;

  always_comb begin
    carry   = adv && step_crosses(int'(dot), STEP, LINE_LEN);
    dot_nxt = DW'(step_dot(int'(dot), STEP, LINE_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst)      dot <= DW'(START_DOT);
    else if (adv) dot <= dot_nxt;
  end

  // R3: in-line step adds STEP
  a_r3_inline_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !carry) |=> ({1'b0, dot} == {1'b0, $past(dot)} + SW'(STEP)));

  // R4: crossing step keeps the leftover dots
  a_r4_carry_dot: assert property (@(posedge clk) disable iff (rst)
    carry |=> ({1'b0, dot} + SW'(LINE_LEN) == {1'b0, $past(dot)} + SW'(STEP)));

  // R2: no tick, dot holds
  a_r2_dot_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(dot));

  // R7: dot stays inside the line
  a_r7_dot_range: assert property (@(posedge clk) disable iff (rst)
    dot < DW'(LINE_LEN));

endmodule

// File: rtl/line_stepper.sv
module line_stepper #(
  parameter int unsigned FRAME_LEN  = 262,
  parameter int unsigned START_LINE = 241,
  parameter int unsigned LW         = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [LW-1:0] line,
  output logic          frame_wrap
);
  import ppu_timebase_pkg::*;

  localparam logic [LW-1:0] LAST = LW'(FRAME_LEN - 1);

  logic [LW-1:0] line_nxt;

  always_comb begin
    frame_wrap = adv && (line == LAST);
    line_nxt   = LW'(next_line(int'(line), FRAME_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst)      line <= LW'(START_LINE);
    else if (adv) line <= line_nxt;
  end

  // R4: line advances by one inside the frame
  a_r4_line_adv: assert property (@(posedge clk) disable iff (rst)
    (adv && line != LAST) |=> (line == $past(line) + LW'(1)));

  // R6: leaving the last line returns to zero
  a_r6_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (line == '0));

  // R2: no carry, line holds
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(line));

endmodule

// File: rtl/line_report.sv
module line_report #(
  parameter int unsigned FRAME_LEN = 262,
  parameter int unsigned LW        = 9,
  parameter int unsigned OW        = 10
) (
  input  logic [LW-1:0] line,
  output logic [OW-1:0] reported
);
  localparam logic [LW-1:0] PRE = LW'(FRAME_LEN - 1);

  always_comb begin
    if (line == PRE) reported = '1;
    else             reported = OW'(line);
  end

endmodule

// File: rtl/ppu_timebase.sv
module ppu_timebase #(
  parameter int unsigned LINE_LEN  = 341,
  parameter int unsigned FRAME_LEN = 262,
  parameter int unsigned STEP      = 3,
  parameter int unsigned START_DOT = 0,
  parameter int          START_LINE = 241,
  localparam int unsigned DW = $clog2(LINE_LEN),
  localparam int unsigned LW = $clog2(FRAME_LEN),
  localparam int unsigned OW = LW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_tick,
  output logic [DW-1:0] dot_count,
  output logic [OW-1:0] scanline
);
  import ppu_timebase_pkg::*;

  localparam int unsigned START_IDX = line_index(START_LINE, FRAME_LEN);

  logic          line_carry;
  logic          frame_wrap;
  logic [LW-1:0] line_idx;

  dot_stepper #(
    .LINE_LEN(LINE_LEN), .STEP(STEP), .START_DOT(START_DOT), .DW(DW)
  ) u_dot (
    .clk(clk), .rst(rst), .adv(cpu_tick), .dot(dot_count), .carry(line_carry)
  );

  line_stepper #(
    .FRAME_LEN(FRAME_LEN), .START_LINE(START_IDX), .LW(LW)
  ) u_line (
    .clk(clk), .rst(rst), .adv(line_carry), .line(line_idx), .frame_wrap(frame_wrap)
  );

  line_report #(
    .FRAME_LEN(FRAME_LEN), .LW(LW), .OW(OW)
  ) u_rep (
    .line(line_idx), .reported(scanline)
  );

  // R5: pre-render line shows as -1
  a_r5_pre_neg: assert property (@(posedge clk) disable iff (rst)
    (line_idx == LW'(FRAME_LEN - 1)) |-> (scanline == '1));

  // R7: reported line in -1..FRAME_LEN-2
  a_r7_line_range: assert property (@(posedge clk) disable iff (rst)
    (scanline == '1) || ($signed(scanline) >= 0 && scanline < OW'(FRAME_LEN - 1)));

  // R6: wrap only ever lands on line 0 from -1
  a_r6_from_pre: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |-> (scanline == '1));

  // R8: reset wins over tick
  a_r8_reset_prio: assert property (@(posedge clk)
    rst |=> (dot_count == DW'(START_DOT)));

endmodule

// File: tb/tb_ppu_timebase.sv
module tb_ppu_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // cumulative ticks since reset, expected dot, expected scanline
  localparam int VEC [NVEC][3] = '{
    '{1,    3,   241},
    '{113,  339, 241},
    '{114,  1,   242},
    '{227,  340, 242},
    '{228,  2,   243},
    '{2273, 340, 260},
    '{2274, 2,   -1},
    '{2386, 338, -1},
    '{2387, 0,   0},
    '{2388, 3,   0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_tick = 1'b0;
  logic [8:0] dot_count;
  logic [9:0] scanline;

  int checks = 0;
  int fails = 0;
  int range_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppu_timebase dut (
    .clk(clk), .rst(rst), .cpu_tick(cpu_tick),
    .dot_count(dot_count), .scanline(scanline)
  );

  task automatic check(string req, int exp_dot, int exp_line);
    int got_line;
    got_line = int'($signed(scanline));
    checks++;
    if (int'(dot_count) != exp_dot || got_line != exp_line) begin
      fails++;
      $display("FAIL %s: got dot=%0d line=%0d expected dot=%0d line=%0d",
               req, dot_count, got_line, exp_dot, exp_line);
    end
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      cpu_tick = 1'b1;
      repeat (n) @(negedge clk);
      cpu_tick = 1'b0;
    end
  endtask

  // R7 monitor: sampled away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      if (dot_count > 9'd340) range_bad++;
      if (!($signed(scanline) >= -1 && $signed(scanline) <= 260)) range_bad++;
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int done_ticks;
    repeat (3) @(negedge clk);
    check("R1 reset state", 0, 241);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle after reset", 0, 241);

    // table walk, R3 R4 R5 R6
    done_ticks = 0;
    for (int i = 0; i < NVEC; i++) begin
      ticks(VEC[i][0] - done_ticks);
      done_ticks = VEC[i][0];
      check($sformatf("R3/R4/R5/R6 vector %0d", i), VEC[i][1], VEC[i][2]);
    end

    // R2: hold with tick low
    repeat (6) @(negedge clk);
    check("R2 hold", 3, 0);

    // R3 gap between ticks
    ticks(2);
    @(negedge clk);
    ticks(1);
    check("R3 after gap", 12, 0);

    // R8: reset with tick high
    cpu_tick = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cpu_tick = 1'b0;
    check("R8 reset priority", 0, 241);

    // R1 again after resuming
    ticks(114);
    check("R4 carry after re-reset", 1, 242);

    checks++;
    if (range_bad != 0) begin
      fails++;
      $display("FAIL R7 range: got %0d violations expected 0", range_bad);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule